// File: doc/BRIEF.md
# Single-Level Page Table Translator

This block turns a virtual address into a physical address by looking up one entry of a flat page table. The table sits in a memory that the block reads through a request/response port with valid/ready handshakes. The caller provides a table base address and a highest legal page index. It then hands over a virtual address together with a write flag and a supervisor-mode flag.

The block returns either a translated physical address or one fault code. The lookup that performs the translation also applies three checks: a range check against the highest legal page index, a presence check on the entry's valid bit, and an access-permission check on the entry's writable and supervisor bits. Only one translation is in flight at a time. The table base and the index limit are sampled when a request is accepted.

Top module: `ptw_translator`

## Requirements
- R1: A successful translation returns `{ppn, offset}`. The 12 low offset bits are copied unchanged from the virtual address. The ppn is taken from PTE bits [31:12]. The fault code for this case is 0.
- R2: The table read address equals the sampled base plus the virtual page number (virtual address bits [31:12]) times 4. The read address and its valid stay stable while the table port stalls.
- R3: If the virtual page number is strictly greater than the sampled limit, the block returns fault code 1 and issues no table read. A page number equal to the limit is translated.
- R4: An entry with bit 0 (valid) clear gives fault code 2. This takes priority over any permission outcome.
- R5: A valid entry with bit 2 (supervisor) set, accessed with the supervisor flag low, gives fault code 3. The same access with the supervisor flag high succeeds.
- R6: A write to a valid entry with bit 1 (writable) clear gives fault code 3. A read of that same entry succeeds.
- R7: Whenever a nonzero fault code is returned, the physical address output is zero.
- R8: Request ready is high in every cycle when no translation is in flight. It drops the cycle after a request is accepted and returns the cycle after the response is taken.
- R9: While a response is valid and not accepted, its valid, address and fault code hold steady.
- R10: Changes to the base or limit inputs after a request is accepted do not affect that translation.
- R11: After reset, request ready is high, and both response valid and table-read valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tbl_base_i | input | 32 | Byte address of table entry 0 |
| tbl_limit_i | input | 20 | Highest legal virtual page number |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_va_i | input | 32 | Virtual address |
| req_write_i | input | 1 | Access is a write |
| req_super_i | input | 1 | Access is made in supervisor mode |
| rsp_valid_o | output | 1 | Result valid |
| rsp_ready_i | input | 1 | Result accepted |
| rsp_pa_o | output | 32 | Physical address, zero on fault |
| rsp_fault_o | output | 2 | 0 none, 1 bounds, 2 page, 3 protection |
| mem_req_valid_o | output | 1 | Table read request valid |
| mem_req_ready_i | input | 1 | Table memory accepts read |
| mem_req_addr_o | output | 32 | Table entry byte address |
| mem_rsp_valid_i | input | 1 | Table read data valid |
| mem_rsp_ready_o | output | 1 | Block waiting for table data |
| mem_rsp_data_i | input | 32 | Page table entry |

## Verification
The assertions assume that the table memory returns read data only after it has accepted a read. They also assume that read data is presented only while the block signals it is waiting. The bench memory model offers data only after its own accepted read and only when the waiting signal is high. It also stalls its read acceptance in a repeating pattern, so the hold checks on the read port see real stalls. The request side drives at most one request per free slot. It holds the response-ready input low for several cycles on selected translations so that the output hold rule is exercised.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_BOUNDS = 2'd1,
    FLT_PAGE   = 2'd2,
    FLT_PROT   = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_RESP
  } state_e;

  localparam int unsigned PTE_VALID_BIT = 0;
  localparam int unsigned PTE_WR_BIT    = 1;
  localparam int unsigned PTE_SUP_BIT   = 2;
endpackage

// File: rtl/ptw_bound_chk.sv
module ptw_bound_chk #(
  parameter int unsigned VPN_W = 20
) (
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [VPN_W-1:0] limit_i,
  output logic             oob_o
);
  assign oob_o = vpn_i > limit_i;
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned TAW    = 32,
  parameter int unsigned PTE_LG = 2
) (
  input  logic [TAW-1:0]   base_i,
  input  logic [VPN_W-1:0] vpn_i,
  output logic [TAW-1:0]   addr_o
);
  localparam int unsigned EXT_W = (VPN_W + PTE_LG > TAW) ? TAW : VPN_W + PTE_LG;

  logic [EXT_W-1:0] idx_scaled;

  generate
    if (VPN_W + PTE_LG > TAW) begin : g_trunc
      logic [VPN_W+PTE_LG-1:0] full;
      assign full       = {vpn_i, {PTE_LG{1'b0}}};
      assign idx_scaled = full[EXT_W-1:0];
    end else begin : g_full
      assign idx_scaled = {vpn_i, {PTE_LG{1'b0}}};
    end
  endgenerate

  assign addr_o = base_i + TAW'(idx_scaled);
endmodule

// File: rtl/ptw_pte_chk.sv
module ptw_pte_chk
  import ptw_pkg::*;
#(
  parameter int unsigned PTE_W = 32,
  parameter int unsigned PPN_W = 20
) (
  input  logic [PTE_W-1:0] pte_i,
  input  logic             is_write_i,
  input  logic             is_super_i,
  output fault_e           fault_o,
  output logic [PPN_W-1:0] ppn_o
);
  logic present, writable, sup_only, prot_bad;

  assign present  = pte_i[PTE_VALID_BIT];
  assign writable = pte_i[PTE_WR_BIT];
  assign sup_only = pte_i[PTE_SUP_BIT];
  assign ppn_o    = pte_i[PTE_W-1 -: PPN_W];

  // user touching a supervisor page, or write to a read-only page
  assign prot_bad = (sup_only && !is_super_i) || (is_write_i && !writable);

  always_comb begin
    if (!present)      fault_o = FLT_PAGE;
    else if (prot_bad) fault_o = FLT_PROT;
    else               fault_o = FLT_NONE;
  end
endmodule

// File: rtl/ptw_translator.sv
module ptw_translator
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned PTE_W = 32,
  parameter int unsigned TAW   = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [TAW-1:0]          tbl_base_i,
  input  logic [VA_W-OFF_W-1:0]   tbl_limit_i,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic [VA_W-1:0]         req_va_i,
  input  logic                    req_write_i,
  input  logic                    req_super_i,
  output logic                    rsp_valid_o,
  input  logic                    rsp_ready_i,
  output logic [PA_W-1:0]         rsp_pa_o,
  output logic [1:0]              rsp_fault_o,
  output logic                    mem_req_valid_o,
  input  logic                    mem_req_ready_i,
  output logic [TAW-1:0]          mem_req_addr_o,
  input  logic                    mem_rsp_valid_i,
  output logic                    mem_rsp_ready_o,
  input  logic [PTE_W-1:0]        mem_rsp_data_i
);
  localparam int unsigned VPN_W  = VA_W - OFF_W;
  localparam int unsigned PPN_W  = PA_W - OFF_W;
  localparam int unsigned PTE_LG = $clog2(PTE_W / 8);

  state_e               state_q;
  logic [OFF_W-1:0]     off_q;
  logic                 wr_q, sup_q;
  logic [TAW-1:0]       addr_q;
  logic [PA_W-1:0]      pa_q;
  fault_e               fault_q;

  logic [VPN_W-1:0]     req_vpn;
  logic                 oob;
  logic [TAW-1:0]       tbl_addr;
  fault_e               pte_fault;
  logic [PPN_W-1:0]     pte_ppn;
  logic                 accept;

  assign req_vpn = req_va_i[VA_W-1:OFF_W];

  ptw_bound_chk #(.VPN_W(VPN_W)) u_bound (
    .vpn_i   (req_vpn),
    .limit_i (tbl_limit_i),
    .oob_o   (oob)
  );

  ptw_addr_gen #(.VPN_W(VPN_W), .TAW(TAW), .PTE_LG(PTE_LG)) u_addr (
    .base_i (tbl_base_i),
    .vpn_i  (req_vpn),
    .addr_o (tbl_addr)
  );

  ptw_pte_chk #(.PTE_W(PTE_W), .PPN_W(PPN_W)) u_pte (
    .pte_i      (mem_rsp_data_i),
    .is_write_i (wr_q),
    .is_super_i (sup_q),
    .fault_o    (pte_fault),
    .ppn_o      (pte_ppn)
  );

  assign req_ready_o     = (state_q == ST_IDLE);
  assign accept          = req_valid_i && req_ready_o;
  assign mem_req_valid_o = (state_q == ST_FETCH);
  assign mem_req_addr_o  = addr_q;
  assign mem_rsp_ready_o = (state_q == ST_WAIT);
  assign rsp_valid_o     = (state_q == ST_RESP);
  assign rsp_pa_o        = pa_q;
  assign rsp_fault_o     = fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      off_q   <= '0;
      wr_q    <= 1'b0;
      sup_q   <= 1'b0;
      addr_q  <= '0;
      pa_q    <= '0;
      fault_q <= FLT_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          off_q <= req_va_i[OFF_W-1:0];
          wr_q  <= req_write_i;
          sup_q <= req_super_i;
          if (oob) begin
            pa_q    <= '0;
            fault_q <= FLT_BOUNDS;
            state_q <= ST_RESP;
          end else begin
            addr_q  <= tbl_addr;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: if (mem_req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid_i) begin
          fault_q <= pte_fault;
          pa_q    <= (pte_fault == FLT_NONE) ? {pte_ppn, off_q} : '0;
          state_q <= ST_RESP;
        end
        ST_RESP: if (rsp_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3: out-of-range page index answers with a bounds fault next cycle, no read
  a_r3_bounds_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && (req_vpn > tbl_limit_i)) |=> (rsp_valid_o && rsp_fault_o == FLT_BOUNDS && !mem_req_valid_o));

  // R4: a non-present entry always reports a page fault
  a_r4_page_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rsp_valid_i && mem_rsp_ready_o && !mem_rsp_data_i[PTE_VALID_BIT]) |=> (rsp_valid_o && rsp_fault_o == FLT_PAGE));

  // R7: faulting responses carry a zero address
  a_r7_fault_zero_pa: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o != FLT_NONE) |-> (rsp_pa_o == '0));

  // R1: offset passes through on success
  a_r1_offset_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !oob) |=> (off_q == $past(req_va_i[OFF_W-1:0])));

  // R8: single outstanding translation
  a_r8_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !req_ready_o);
  a_r8_free_after_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_ready_i) |=> req_ready_o);

  // R9: response held while stalled
  a_r9_rsp_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_pa_o) && $stable(rsp_fault_o)));

  // R2: table read held while stalled
  a_r2_mem_req_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));
endmodule

// File: tb/tb_ptw_translator.sv
module tb_ptw_translator;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] tbl_base_i = '0;
  logic [19:0] tbl_limit_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_va_i = '0;
  logic        req_write_i = 1'b0;
  logic        req_super_i = 1'b0;
  logic        rsp_valid_o;
  logic        rsp_ready_i = 1'b0;
  logic [31:0] rsp_pa_o;
  logic [1:0]  rsp_fault_o;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [31:0] mem_req_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic        mem_rsp_ready_o;
  logic [31:0] mem_rsp_data_i = '0;

  int errors = 0;
  int checks = 0;
  int reads = 0;
  int cyc = 0;
  logic [31:0] exp_addr = '0;
  logic        busy = 1'b0;

  always #5 clk_i = ~clk_i;

  ptw_translator dut (
    .clk_i, .rst_ni, .tbl_base_i, .tbl_limit_i,
    .req_valid_i, .req_ready_o, .req_va_i, .req_write_i, .req_super_i,
    .rsp_valid_o, .rsp_ready_i, .rsp_pa_o, .rsp_fault_o,
    .mem_req_valid_o, .mem_req_ready_i, .mem_req_addr_o,
    .mem_rsp_valid_i, .mem_rsp_ready_o, .mem_rsp_data_i
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // table contents derived from the entry address; flags = address bits [4:2]
  function automatic logic [31:0] pte_for(input logic [31:0] a);
    return {a[21:2] ^ 20'h5A5A5, 9'b0, a[4:2]};
  endfunction

  // table memory model
  bit          pend = 0;
  int          lat = 0;
  logic [31:0] lat_addr = '0;
  always @(negedge clk_i) begin
    cyc++;
    if (!rst_ni) begin
      pend = 0; mem_rsp_valid_i = 0; mem_req_ready_i = 0;
    end else begin
      if (mem_rsp_valid_i) mem_rsp_valid_i = 0;
      else if (pend && lat == 0 && mem_rsp_ready_o) begin
        mem_rsp_valid_i = 1; mem_rsp_data_i = pte_for(lat_addr); pend = 0;
      end else if (pend && lat > 0) lat--;
      mem_req_ready_i = (cyc % 3) != 0;
      if (mem_req_valid_o && mem_req_ready_i) begin
        chk(mem_req_addr_o == exp_addr, "R2 table address", mem_req_addr_o, exp_addr);
        pend = 1; lat = cyc % 3; lat_addr = mem_req_addr_o; reads++;
      end
    end
  end

  // per-clock occupancy model
  always begin
    @(posedge clk_i);
    if (!rst_ni) busy = 0;
    else begin
      if (rsp_valid_o && rsp_ready_i) busy = 0;
      if (req_valid_i && req_ready_o) busy = 1;
    end
    #2;
    if (rst_ni) chk(req_ready_o == !busy, "R8 ready vs occupancy", req_ready_o, !busy);
  end

  task automatic xlate(input logic [31:0] va, input bit wr, input bit sup,
                       input logic [31:0] base, input logic [19:0] lim,
                       input string tag, input bit hold, input bit scramble);
    logic [1:0]  ef;
    logic [31:0] ep, pte, pa0;
    int r0;
    if (va[31:12] > lim) begin ef = 2'd1; ep = '0; end
    else begin
      exp_addr = base + {va[31:12], 2'b00};
      pte = pte_for(exp_addr);
      if (!pte[0]) begin ef = 2'd2; ep = '0; end
      else if ((!sup && pte[2]) || (wr && !pte[1])) begin ef = 2'd3; ep = '0; end
      else begin ef = 2'd0; ep = {pte[31:12], va[11:0]}; end
    end
    r0 = reads;
    @(negedge clk_i);
    tbl_base_i = base; tbl_limit_i = lim;
    req_va_i = va; req_write_i = wr; req_super_i = sup; req_valid_i = 1;
    @(negedge clk_i);
    req_valid_i = 0;
    if (scramble) begin tbl_base_i = ~base; tbl_limit_i = '0; end
    while (!rsp_valid_o) @(negedge clk_i);
    chk(rsp_fault_o == ef, {tag, " fault"}, rsp_fault_o, ef);
    chk(rsp_pa_o == ep, {tag, " address"}, rsp_pa_o, ep);
    if (ef != 0) chk(rsp_pa_o == 0, "R7 zero on fault", rsp_pa_o, 0);
    if (ef == 2'd1) chk(reads == r0, "R3 no table read", reads - r0, 0);
    if (hold) begin
      pa0 = rsp_pa_o;
      repeat (2) begin
        @(negedge clk_i);
        chk(rsp_valid_o && rsp_pa_o == pa0 && rsp_fault_o == ef, "R9 held response",
            {rsp_valid_o, rsp_fault_o, rsp_pa_o}, {1'b1, ef, pa0});
      end
    end
    rsp_ready_i = 1;
    @(negedge clk_i);
    rsp_ready_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk(req_ready_o && !rsp_valid_o && !mem_req_valid_o, "R11 reset state",
        {req_ready_o, rsp_valid_o, mem_req_valid_o}, 3'b100);

    // vpn low bits select flags when base is 32-byte aligned
    xlate(32'h0000_3ABC, 1, 0, 32'h0001_0000, 20'hFF, "R1", 1, 0);   // flags 011
    xlate(32'h0000_7123, 0, 0, 32'h0001_0000, 20'hFF, "R5 user->sup", 0, 0);
    xlate(32'h0000_7123, 1, 1, 32'h0001_0000, 20'hFF, "R5 sup ok", 0, 0);
    xlate(32'h0000_1456, 1, 0, 32'h0001_0000, 20'hFF, "R6 write ro", 1, 0);
    xlate(32'h0000_1456, 0, 0, 32'h0001_0000, 20'hFF, "R6 read ro", 0, 0);
    xlate(32'h0000_4000, 1, 0, 32'h0001_0000, 20'hFF, "R4 priority", 0, 0);
    xlate(32'h0000_2FFF, 0, 1, 32'h0001_0000, 20'hFF, "R4 invalid", 0, 0);
    xlate(32'h000F_F001, 0, 1, 32'h0002_0000, 20'hFF, "R3 at limit", 0, 0);
    xlate(32'h0010_0001, 0, 1, 32'h0002_0000, 20'hFF, "R3 over limit", 1, 0);
    xlate(32'hFFFF_F000, 0, 0, 32'h0002_0000, 20'hFFFFE, "R3 top", 0, 0);
    xlate(32'h0000_3ABC, 0, 0, 32'h0003_0020, 20'h10, "R10 cfg change", 0, 1);
    xlate(32'h0000_F00D, 1, 1, 32'h0000_1004, 20'h40, "R2 odd base", 0, 0);

    for (int i = 0; i < 60; i++) begin
      xlate({$urandom} % 32'h0004_0000, 1'($urandom), 1'($urandom),
            $urandom & 32'h00FF_FFFC, 20'($urandom % 64), "R1 mix", (i % 5) == 0, (i % 7) == 0);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule